// File: doc/BRIEF.md
# Time-of-Day and Calendar Counter

This block keeps wall-clock time and the calendar date for a real-time clock. A chain of counters for seconds, minutes, hours, day of month, month, two-digit year and weekday advances once for every one-second tick pulse that a separate prescaler delivers. A control field picks either 12-hour counting, with a morning/afternoon flag, or 24-hour counting. The chain knows the length of each month and the extra February day of leap years.

Software loads every counter through a narrow write port: a field select, a data byte and a write strobe. Counting starts and stops through a control field. The hour range can be set in the same control write that starts counting. Each load should be made while the chain is stopped. After a change of hour mode, software reloads the hour and date fields, because the block does not convert them.

A date that cannot exist, such as the 31st of a 30-day month, is not refused. The next day carry turns it into the 1st of the following month.

Top module: `rtc_calendar_top`

## Requirements
- R1: After a synchronous reset the outputs read 00:00:00, flag 0, day 1, month 1, year 0, weekday 0, with counting stopped and 12-hour mode selected.
- R2: While counting runs, each tick adds one to the seconds. Seconds and minutes each count 0 to 59, and the wrap of one carries into the next.
- R3: While counting is stopped, tick pulses change no counter.
- R4: A write with `wr_sel` 0..6 loads seconds, minutes, hour, day, month, year or weekday from the low bits of `wr_data`. For the hour, bits 4:0 hold the hour and bit 7 the afternoon flag. A write cycle blocks any tick arriving in that same cycle.
- R5: A write with `wr_sel` 7 sets run from `wr_data` bit 0 and the 24-hour mode from bit 1, both in one write.
- R6: In 24-hour mode the hours count 0 to 23, the day advances on the 23-to-0 wrap, and `pm_o` reads 0 whatever was written.
- R7: In 12-hour mode the hours count 0 to 11. The flag (0 morning, 1 afternoon) toggles on each 11-to-0 wrap, and the day advances only when the flag goes from 1 to 0.
- R8: Months 4, 6, 9 and 11 have 30 days and February has 28 days. February has 29 days when the year is a multiple of 4, year 0 included. All other months have 31 days.
- R9: A loaded day beyond the month's length becomes day 1 of the next month on the next day carry.
- R10: The month wraps from 12 to 1 and carries into the year, and the year wraps from 99 to 0.
- R11: The weekday counts 0 to 6 and advances on every day carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle pulse, once per second |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 3 | Field select for a write |
| wr_data | input | 8 | Write data |
| run_o | output | 1 | Counting enabled |
| mode24_o | output | 1 | 1 for 24-hour mode, 0 for 12-hour mode |
| sec_o | output | 6 | Seconds |
| min_o | output | 6 | Minutes |
| hour_o | output | 5 | Hours |
| pm_o | output | 1 | Afternoon flag (12-hour mode only) |
| day_o | output | 5 | Day of month, 1 to 31 |
| month_o | output | 4 | Month, 1 to 12 |
| year_o | output | 7 | Year, 0 to 99 |
| dow_o | output | 3 | Weekday, 0 to 6 |

## Verification
The bound checker watches, on every cycle, that a stopped chain holds all its fields and that a seconds write or control write lands in the next cycle. It also watches that the afternoon flag stays low in 24-hour mode, that the seconds step by one on an unblocked tick, and that the weekday and year stay inside their ranges. Some behaviours appear only in the bench's directed scenarios: the carry ripples through the month length table, the leap-year February, invalid-date recovery, the afternoon-to-morning day carry of 12-hour mode, and the wrap from December 99 to January 0.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    localparam int SEC_W  = 6;
    localparam int MIN_W  = 6;
    localparam int HOUR_W = 5;
    localparam int DAY_W  = 5;
    localparam int MON_W  = 4;
    localparam int YEAR_W = 7;
    localparam int DOW_W  = 3;
    localparam int SEL_W  = 3;
    localparam int DATA_W = 8;
    localparam int NUM_SEL = 1 << SEL_W;

    localparam int SEC_LAST    = 59;
    localparam int MIN_LAST    = 59;
    localparam int HOUR24_LAST = 23;
    localparam int HOUR12_LAST = 11;
    localparam int MON_LAST    = 12;
    localparam int YEAR_LAST   = 99;
    localparam int DOW_LAST    = 6;

    localparam int PM_BIT = DATA_W - 1;

    typedef enum logic [SEL_W-1:0] {
        SEL_SEC  = 3'd0,
        SEL_MIN  = 3'd1,
        SEL_HOUR = 3'd2,
        SEL_DAY  = 3'd3,
        SEL_MON  = 3'd4,
        SEL_YEAR = 3'd5,
        SEL_DOW  = 3'd6,
        SEL_CTRL = 3'd7
    } field_sel_e;

    typedef struct packed {
        logic mode24;
        logic run;
    } ctrl_t;

    // Two-digit year: multiples of four are leap years.
    function automatic logic leap_year(input logic [YEAR_W-1:0] y);
        return (y[1:0] == 2'b00);
    endfunction

    function automatic logic [DAY_W-1:0] month_len(input logic [MON_W-1:0] m,
                                                   input logic leap);
        logic [DAY_W-1:0] n;
        case (m)
            4'd2:                    n = leap ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11: n = 5'd30;
            default:                 n = 5'd31;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/rtc_wrap_cnt.sv
module rtc_wrap_cnt #(
    parameter int W     = 6,
    parameter int FIRST = 0,
    parameter int LAST  = 59
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] q,
    output logic         wrap
);
    localparam logic [W-1:0] FIRST_V = W'(FIRST);
    localparam logic [W-1:0] LAST_V  = W'(LAST);

    // ">=" lets an out-of-range load recover on its next step.
    assign wrap = step && (q >= LAST_V);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= FIRST_V;
        end else if (ld) begin
            q <= ld_val;
        end else if (step) begin
            q <= wrap ? FIRST_V : q + 1'b1;
        end
    end
endmodule

// File: rtl/rtc_hour_unit.sv
module rtc_hour_unit
    import rtc_cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic              mode24,
    input  logic              ld,
    input  logic [HOUR_W-1:0] ld_hour,
    input  logic              ld_pm,
    output logic [HOUR_W-1:0] hour,
    output logic              pm,
    output logic              day_step
);
    logic at_last;

    assign at_last  = mode24 ? (hour >= HOUR_W'(HOUR24_LAST))
                             : (hour >= HOUR_W'(HOUR12_LAST));
    // 12-hour mode: the date turns only on the afternoon-to-morning wrap.
    assign day_step = step && at_last && (mode24 || pm);

    always_ff @(posedge clk) begin
        if (rst) begin
            hour <= '0;
            pm   <= 1'b0;
        end else if (ld) begin
            hour <= ld_hour;
            pm   <= ld_pm && !mode24;
        end else if (step) begin
            if (at_last) begin
                hour <= '0;
                if (!mode24) begin
                    pm <= !pm;
                end
            end else begin
                hour <= hour + 1'b1;
            end
        end
    end
endmodule

// File: rtl/rtc_date_unit.sv
module rtc_date_unit
    import rtc_cal_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic             leap,
    input  logic             ld_day,
    input  logic [DAY_W-1:0] ld_day_val,
    input  logic             ld_mon,
    input  logic [MON_W-1:0] ld_mon_val,
    output logic [DAY_W-1:0] day,
    output logic [MON_W-1:0] month,
    output logic             year_step
);
    logic month_end;
    logic year_end;

    // A day past the month's end (invalid load) counts as the last day.
    assign month_end = (day >= month_len(month, leap));
    assign year_end  = (month >= MON_W'(MON_LAST));
    assign year_step = step && month_end && year_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            day   <= DAY_W'(1);
            month <= MON_W'(1);
        end else begin
            if (ld_day) begin
                day <= ld_day_val;
            end else if (step) begin
                day <= month_end ? DAY_W'(1) : day + 1'b1;
            end
            if (ld_mon) begin
                month <= ld_mon_val;
            end else if (step && month_end) begin
                month <= year_end ? MON_W'(1) : month + 1'b1;
            end
        end
    end
endmodule

// File: rtl/rtc_calendar_top.sv
module rtc_calendar_top
    import rtc_cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_1hz,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic              run_o,
    output logic              mode24_o,
    output logic [SEC_W-1:0]  sec_o,
    output logic [MIN_W-1:0]  min_o,
    output logic [HOUR_W-1:0] hour_o,
    output logic              pm_o,
    output logic [DAY_W-1:0]  day_o,
    output logic [MON_W-1:0]  month_o,
    output logic [YEAR_W-1:0] year_o,
    output logic [DOW_W-1:0]  dow_o
);
    logic [NUM_SEL-1:0] ld;
    ctrl_t              ctrl_q;
    logic               step_sec;
    logic               sec_wrap;
    logic               min_wrap;
    logic               day_step;
    logic               year_step;
    logic               year_wrap;
    logic               dow_wrap;
    logic               pm_raw;

    for (genvar i = 0; i < NUM_SEL; i++) begin : g_ld
        assign ld[i] = wr_en && (wr_sel == SEL_W'(i));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (ld[SEL_CTRL]) begin
            ctrl_q.run    <= wr_data[0];
            ctrl_q.mode24 <= wr_data[1];
        end
    end

    // Any write in a cycle suppresses that cycle's tick.
    assign step_sec = tick_1hz && ctrl_q.run && !wr_en;

    rtc_wrap_cnt #(.W(SEC_W), .FIRST(0), .LAST(SEC_LAST)) u_sec (
        .clk(clk), .rst(rst), .step(step_sec), .ld(ld[SEL_SEC]),
        .ld_val(wr_data[SEC_W-1:0]), .q(sec_o), .wrap(sec_wrap)
    );

    rtc_wrap_cnt #(.W(MIN_W), .FIRST(0), .LAST(MIN_LAST)) u_min (
        .clk(clk), .rst(rst), .step(sec_wrap), .ld(ld[SEL_MIN]),
        .ld_val(wr_data[MIN_W-1:0]), .q(min_o), .wrap(min_wrap)
    );

    rtc_hour_unit u_hour (
        .clk(clk), .rst(rst), .step(min_wrap), .mode24(ctrl_q.mode24),
        .ld(ld[SEL_HOUR]), .ld_hour(wr_data[HOUR_W-1:0]),
        .ld_pm(wr_data[PM_BIT]), .hour(hour_o), .pm(pm_raw),
        .day_step(day_step)
    );

    rtc_date_unit u_date (
        .clk(clk), .rst(rst), .step(day_step), .leap(leap_year(year_o)),
        .ld_day(ld[SEL_DAY]), .ld_day_val(wr_data[DAY_W-1:0]),
        .ld_mon(ld[SEL_MON]), .ld_mon_val(wr_data[MON_W-1:0]),
        .day(day_o), .month(month_o), .year_step(year_step)
    );

    rtc_wrap_cnt #(.W(YEAR_W), .FIRST(0), .LAST(YEAR_LAST)) u_year (
        .clk(clk), .rst(rst), .step(year_step), .ld(ld[SEL_YEAR]),
        .ld_val(wr_data[YEAR_W-1:0]), .q(year_o), .wrap(year_wrap)
    );

    rtc_wrap_cnt #(.W(DOW_W), .FIRST(0), .LAST(DOW_LAST)) u_dow (
        .clk(clk), .rst(rst), .step(day_step), .ld(ld[SEL_DOW]),
        .ld_val(wr_data[DOW_W-1:0]), .q(dow_o), .wrap(dow_wrap)
    );

    assign run_o    = ctrl_q.run;
    assign mode24_o = ctrl_q.mode24;
    assign pm_o     = pm_raw && !ctrl_q.mode24;

    logic unused_wraps;
    assign unused_wraps = year_wrap ^ dow_wrap;
endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk
    import rtc_cal_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              tick_1hz,
    input logic              wr_en,
    input logic [SEL_W-1:0]  wr_sel,
    input logic [DATA_W-1:0] wr_data,
    input logic              run_o,
    input logic              mode24_o,
    input logic [SEC_W-1:0]  sec_o,
    input logic [MIN_W-1:0]  min_o,
    input logic [HOUR_W-1:0] hour_o,
    input logic              pm_o,
    input logic [DAY_W-1:0]  day_o,
    input logic [MON_W-1:0]  month_o,
    input logic [YEAR_W-1:0] year_o,
    input logic [DOW_W-1:0]  dow_o
);
    a_r3_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!run_o && !wr_en) |=>
            $stable({sec_o, min_o, hour_o, pm_o, day_o, month_o, year_o, dow_o}));

    a_r2_sec_step: assert property (@(posedge clk) disable iff (rst)
        (run_o && tick_1hz && !wr_en && sec_o < SEC_W'(SEC_LAST)) |=>
            (sec_o == $past(sec_o) + 1'b1));

    a_r4_sec_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == SEL_SEC) |=> (sec_o == $past(wr_data[SEC_W-1:0])));

    a_r5_ctrl_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == SEL_CTRL) |=>
            (run_o == $past(wr_data[0]) && mode24_o == $past(wr_data[1])));

    a_r6_no_pm_24h: assert property (@(posedge clk) disable iff (rst)
        mode24_o |-> !pm_o);

    a_r11_dow_range: assert property (@(posedge clk) disable iff (rst)
        dow_o <= DOW_W'(DOW_LAST));

    a_r10_year_range: assert property (@(posedge clk) disable iff (rst)
        year_o <= YEAR_W'(YEAR_LAST));
endmodule

bind rtc_calendar_top rtc_calendar_chk chk_i (.*);

// File: tb/rtc_calendar_top_tb_top.sv
module rtc_calendar_top_tb_top;
    import rtc_cal_pkg::*;

    typedef struct packed {
        logic       m24;
        logic [5:0] s;
        logic [5:0] mi;
        logic [4:0] h;
        logic       pm;
        logic [4:0] d;
        logic [3:0] mo;
        logic [6:0] y;
        logic [2:0] w;
    } cal_t;

    typedef struct packed {
        cal_t pre;
        cal_t exp;
    } vec_t;

    localparam int NVEC = 15;
    localparam vec_t VECS [NVEC] = '{
        // R2 plain second step
        '{{1'b1,6'd56,6'd34,5'd12,1'b0,5'd5,4'd3,7'd10,3'd2},
          {1'b1,6'd57,6'd34,5'd12,1'b0,5'd5,4'd3,7'd10,3'd2}},
        // R2 second to minute carry
        '{{1'b1,6'd59,6'd0,5'd0,1'b0,5'd5,4'd3,7'd10,3'd2},
          {1'b1,6'd0,6'd1,5'd0,1'b0,5'd5,4'd3,7'd10,3'd2}},
        // R6 R11 day carry at 23:59:59, weekday 6 to 0
        '{{1'b1,6'd59,6'd59,5'd23,1'b0,5'd15,4'd6,7'd20,3'd6},
          {1'b1,6'd0,6'd0,5'd0,1'b0,5'd16,4'd6,7'd20,3'd0}},
        // R7 morning to afternoon, no day carry
        '{{1'b0,6'd59,6'd59,5'd11,1'b0,5'd10,4'd7,7'd21,3'd3},
          {1'b0,6'd0,6'd0,5'd0,1'b1,5'd10,4'd7,7'd21,3'd3}},
        // R7 afternoon to morning, day carry
        '{{1'b0,6'd59,6'd59,5'd11,1'b1,5'd10,4'd7,7'd21,3'd3},
          {1'b0,6'd0,6'd0,5'd0,1'b0,5'd11,4'd7,7'd21,3'd4}},
        // R8 Feb 28 in non-leap year
        '{{1'b1,6'd59,6'd59,5'd23,1'b0,5'd28,4'd2,7'd23,3'd1},
          {1'b1,6'd0,6'd0,5'd0,1'b0,5'd1,4'd3,7'd23,3'd2}},
        // R8 Feb 28 in leap year
        '{{1'b1,6'd59,6'd59,5'd23,1'b0,5'd28,4'd2,7'd24,3'd1},
          {1'b1,6'd0,6'd0,5'd0,1'b0,5'd29,4'd2,7'd24,3'd2}},
        // R8 Feb 29 in leap year
        '{{1'b1,6'd59,6'd59,5'd23,1'b0,5'd29,4'd2,7'd24,3'd2},
          {1'b1,6'd0,6'd0,5'd0,1'b0,5'd1,4'd3,7'd24,3'd3}},
        // R8 end of a 30-day month
        '{{1'b1,6'd59,6'd59,5'd23,1'b0,5'd30,4'd4,7'd7,3'd5},
          {1'b1,6'd0,6'd0,5'd0,1'b0,5'd1,4'd5,7'd7,3'd6}},
        // R8 30th of a 31-day month
        '{{1'b1,6'd59,6'd59,5'd23,1'b0,5'd30,4'd1,7'd7,3'd5},
          {1'b1,6'd0,6'd0,5'd0,1'b0,5'd31,4'd1,7'd7,3'd6}},
        // R9 invalid 31st of a 30-day month
        '{{1'b1,6'd59,6'd59,5'd23,1'b0,5'd31,4'd4,7'd5,3'd0},
          {1'b1,6'd0,6'd0,5'd0,1'b0,5'd1,4'd5,7'd5,3'd1}},
        // R9 invalid Feb 29 in non-leap year
        '{{1'b1,6'd59,6'd59,5'd23,1'b0,5'd29,4'd2,7'd6,3'd4},
          {1'b1,6'd0,6'd0,5'd0,1'b0,5'd1,4'd3,7'd6,3'd5}},
        // R10 year 99 wraps to 0
        '{{1'b1,6'd59,6'd59,5'd23,1'b0,5'd31,4'd12,7'd99,3'd6},
          {1'b1,6'd0,6'd0,5'd0,1'b0,5'd1,4'd1,7'd0,3'd0}},
        // R10 December to January carries into year
        '{{1'b1,6'd59,6'd59,5'd23,1'b0,5'd31,4'd12,7'd41,3'd3},
          {1'b1,6'd0,6'd0,5'd0,1'b0,5'd1,4'd1,7'd42,3'd4}},
        // R7 mid-range hour step keeps flag
        '{{1'b0,6'd59,6'd59,5'd5,1'b1,5'd3,4'd3,7'd3,3'd0},
          {1'b0,6'd0,6'd0,5'd6,1'b1,5'd3,4'd3,7'd3,3'd0}}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              tick_1hz = 1'b0;
    logic              wr_en = 1'b0;
    logic [SEL_W-1:0]  wr_sel = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              run_o, mode24_o, pm_o;
    logic [SEC_W-1:0]  sec_o;
    logic [MIN_W-1:0]  min_o;
    logic [HOUR_W-1:0] hour_o;
    logic [DAY_W-1:0]  day_o;
    logic [MON_W-1:0]  month_o;
    logic [YEAR_W-1:0] year_o;
    logic [DOW_W-1:0]  dow_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = !clk;

    rtc_calendar_top dut_i (
        .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .run_o(run_o),
        .mode24_o(mode24_o), .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o),
        .pm_o(pm_o), .day_o(day_o), .month_o(month_o), .year_o(year_o),
        .dow_o(dow_o)
    );

    function automatic cal_t snap();
        return {mode24_o, sec_o, min_o, hour_o, pm_o, day_o, month_o, year_o, dow_o};
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_cal(input string req, input cal_t act, input cal_t exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
        tick_1hz = 1'b1;
        @(negedge clk);
        tick_1hz = 1'b0;
    endtask

    task automatic load(input cal_t c, input logic run);
        wr(3'd7, {6'd0, c.m24, 1'b0});
        wr(3'd0, {2'd0, c.s});
        wr(3'd1, {2'd0, c.mi});
        wr(3'd2, {c.pm, 2'd0, c.h});
        wr(3'd3, {3'd0, c.d});
        wr(3'd4, {4'd0, c.mo});
        wr(3'd5, {1'b0, c.y});
        wr(3'd6, {5'd0, c.w});
        wr(3'd7, {6'd0, c.m24, run});
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check_cal("R1 reset fields", snap(),
                  {1'b0,6'd0,6'd0,5'd0,1'b0,5'd1,4'd1,7'd0,3'd0});
        check("R1 reset run", int'(run_o), 0);

        // R2..R11 vector table: preload, one tick, compare
        for (int i = 0; i < NVEC; i++) begin
            load(VECS[i].pre, 1'b1);
            tick();
            check_cal($sformatf("vector %0d (R2/R6/R7/R8/R9/R10/R11)", i),
                      snap(), VECS[i].exp);
        end

        // R3 stopped chain ignores ticks
        load({1'b1,6'd30,6'd20,5'd10,1'b0,5'd9,4'd9,7'd9,3'd1}, 1'b0);
        tick(); tick(); tick();
        check_cal("R3 idle ignores ticks", snap(),
                  {1'b1,6'd30,6'd20,5'd10,1'b0,5'd9,4'd9,7'd9,3'd1});

        // R5 run and mode set in one control write
        wr(3'd7, 8'h03);
        check("R5 run set", int'(run_o), 1);
        check("R5 mode set", int'(mode24_o), 1);

        // R4 write beats a tick in the same cycle
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 3'd0; wr_data = 8'd5; tick_1hz = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick_1hz = 1'b0;
        check("R4 write priority sec", int'(sec_o), 5);
        check("R4 write priority min", int'(min_o), 20);

        // R2 full minute: 55 ticks from 5 s
        for (int k = 0; k < 55; k++) tick();
        check("R2 sec wrap", int'(sec_o), 0);
        check("R2 min carry", int'(min_o), 21);

        // R6 flag written as 1 reads 0 in 24-hour mode
        wr(3'd2, 8'h87);
        check("R6 hour load", int'(hour_o), 7);
        check("R6 pm forced 0", int'(pm_o), 0);

        // R6 switch from 12-hour afternoon to 24-hour hides flag
        wr(3'd7, 8'h00);
        wr(3'd2, 8'h83);
        check("R7 pm held in 12h", int'(pm_o), 1);
        wr(3'd7, 8'h02);
        check("R6 pm masked after mode change", int'(pm_o), 0);

        finish_run();
    end
endmodule